// File: doc/BRIEF.md
# Priority Encoder with Active-Low Idle Flag

This block turns a vector of request lines into the binary position of the highest-numbered line that is asserted. The line with the largest position wins; every line below it is ignored. A separate active-low flag goes high only when no line is asserted at all. Without it, "nothing requested" and "line 0 requested" would both produce an index of zero.

The block is purely combinational and has no clock or reset. Its outputs follow its inputs within the same cycle. The width is set by a single parameter, `SEL_W`. The request vector then has `2**SEL_W` lines, and the index has `SEL_W` bits. The default is four lines and a two-bit index. Internally the encoder is a balanced tree of two-way merge cells over single-bit leaf cells. Each merge level adds one bit of the index.

Top module: `prio_enc_top`

## Requirements
- R1: When every bit of `req` is 0, `none_n` is 1.
- R2: When every bit of `req` is 0, `idx` is all zeros (never X or Z).
- R3: When at least one bit of `req` is 1, `none_n` is 0.
- R4: When `none_n` is 0, `idx` equals the bit position of the most significant 1 in `req`. Position 0 is `req[0]`, and position `2**SEL_W-1` is the highest priority.
- R5: With exactly one bit of `req` set at position p, `idx` is p and `none_n` is 0. This includes p = 0, which is told apart from the idle case only by `none_n`.
- R6: Bits of `req` below the most significant set bit have no effect on `idx` or `none_n`. For example, `req` = 4'b1111 and `req` = 4'b1000 both give `idx` = 3.
- R7: `idx` and `none_n` settle in the same cycle as `req` changes. No clock edge lies between input and output.
- R8: The same rules hold for any `SEL_W` of 1 or more. With `SEL_W` = 3, all 256 eight-bit patterns obey R1 to R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req | input | 2**SEL_W | Request lines; a higher bit position means higher priority |
| idx | output | SEL_W | Binary position of the highest asserted request, zero when idle |
| none_n | output | 1 | Active-low activity flag; 1 means no request is asserted |

## Verification
Two functions coincide in a single pattern: the idle flag and priority resolution. Each of `req` = 0 and `req` = 1 yields `idx` = 0, so only the flag separates them. These two patterns are applied back to back to provoke that case. Patterns with several bits set, such as all ones, exercise priority resolution against the masking of lower bits. Every pattern of the four-line instance and of an eight-line instance is driven in turn. A reference loop in the bench scans from the top bit downward and predicts both outputs, and these predictions are compared against the outputs half a clock later.

// File: rtl/prio_enc_pkg.sv
// Package: shared constants for the priority encoder tree.
// Assumes: nothing; holds only defaults used by the top module.
package prio_enc_pkg;
    // Default index width; four request lines.
    localparam int unsigned DEF_SEL_W = 2;
endpackage

// File: rtl/prio_leaf_cell.sv
// Module: prio_leaf_cell
// Turns one request line into a tree node: valid = the line, index = 0.
// Assumes: a single request bit; the index width matches the tree.
module prio_leaf_cell #(
    parameter int unsigned SEL_W = 2
) (
    input  logic             line_i,
    output logic             node_vld_o,
    output logic [SEL_W-1:0] node_idx_o
);
    // Leaf: a subtree of one line has no index bits of its own.
    always_comb begin
        node_vld_o = line_i;
        node_idx_o = '0;
    end
endmodule

// File: rtl/prio_merge_cell.sv
// Module: prio_merge_cell
// Joins two sibling subtrees of equal height. The upper subtree wins when
// valid and sets index bit BIT_POS; otherwise the lower subtree passes through.
// Assumes: child indices carry zeros at BIT_POS and above, and an invalid
// child presents an all-zero index.
module prio_merge_cell #(
    parameter int unsigned SEL_W   = 2,
    parameter int unsigned BIT_POS = 0
) (
    input  logic             lo_vld_i,
    input  logic [SEL_W-1:0] lo_idx_i,
    input  logic             hi_vld_i,
    input  logic [SEL_W-1:0] hi_idx_i,
    output logic             vld_o,
    output logic [SEL_W-1:0] idx_o
);
    localparam logic [SEL_W-1:0] POS_MASK = SEL_W'(1) << BIT_POS;

    // Merge: upper half takes precedence; an idle pair yields a zero index.
    always_comb begin
        vld_o = hi_vld_i | lo_vld_i;
        if (hi_vld_i) begin
            idx_o = hi_idx_i | POS_MASK;
        end else begin
            idx_o = lo_idx_i;
        end
    end
endmodule

// File: rtl/prio_enc_top.sv
// Module: prio_enc_top
// Combinational priority encoder over 2**SEL_W request lines. The output
// index is the position of the most significant asserted line; none_n is
// high only when no line is asserted.
// Assumes: SEL_W >= 1. Tree nodes use heap numbering: node 1 is the root,
// node n has children 2n (lower half) and 2n+1 (upper half), and leaves
// N..2N-1 map to req[0]..req[N-1].
module prio_enc_top
    import prio_enc_pkg::*;
#(
    parameter int unsigned SEL_W = DEF_SEL_W
) (
    input  logic [(1<<SEL_W)-1:0] req,
    output logic [SEL_W-1:0]      idx,
    output logic                  none_n
);
    localparam int unsigned N_LINES = 1 << SEL_W;
    localparam int unsigned N_NODES = 2 * N_LINES - 1;

    logic             nd_vld [1:N_NODES];
    logic [SEL_W-1:0] nd_idx [1:N_NODES];

    // Leaves: one cell per request line.
    for (genvar p = 0; p < N_LINES; p++) begin : g_leaf
        prio_leaf_cell #(.SEL_W(SEL_W)) u_leaf (
            .line_i     (req[p]),
            .node_vld_o (nd_vld[N_LINES + p]),
            .node_idx_o (nd_idx[N_LINES + p])
        );
    end

    // Internal nodes: a node at depth d covers SEL_W-d levels and adds bit SEL_W-d-1.
    for (genvar n = 1; n < N_LINES; n++) begin : g_node
        localparam int unsigned HEIGHT = SEL_W - $clog2(n + 1) + 1;
        prio_merge_cell #(.SEL_W(SEL_W), .BIT_POS(HEIGHT - 1)) u_merge (
            .lo_vld_i (nd_vld[2*n]),
            .lo_idx_i (nd_idx[2*n]),
            .hi_vld_i (nd_vld[2*n + 1]),
            .hi_idx_i (nd_idx[2*n + 1]),
            .vld_o    (nd_vld[n]),
            .idx_o    (nd_idx[n])
        );
    end

    // Outputs: root index and inverted root valid.
    always_comb begin
        idx    = nd_idx[1];
        none_n = ~nd_vld[1];
    end

    // Checks relating the raw request vector to the tree's root outputs.
    always_comb begin
        AST_IDLE_FLAG_HIGH: assert ((req == '0) == none_n) else $error("idle flag mismatch"); // R1
        AST_IDLE_INDEX_ZERO: assert (!none_n || idx == '0) else $error("idle index nonzero"); // R2
        AST_ACTIVE_FLAG_LOW: assert ((req != '0) == !none_n) else $error("active flag mismatch"); // R3
        AST_INDEX_LINE_SET: assert (none_n || req[idx]) else $error("index names an idle line"); // R4
        AST_NOTHING_ABOVE: assert (none_n || (req >> idx) == 1) else $error("higher line ignored"); // R6
    end
endmodule

// File: tb/tb_prio_enc_top.sv
module tb_prio_enc_top;
    localparam real HALF_NS = 4.0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req4 = '0;
    logic [1:0] idx4;
    logic       nn4;
    logic [7:0] req8 = '0;
    logic [2:0] idx8;
    logic       nn8;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        bit       wide;
        int       idx;
        bit       nn;
        int       pat;
        string    tag;
    } exp_t;
    exp_t sb[$];

    always #(HALF_NS) clk = ~clk;

    prio_enc_top #(.SEL_W(2)) dut (.req(req4), .idx(idx4), .none_n(nn4));
    prio_enc_top #(.SEL_W(3)) dut8 (.req(req8), .idx(idx8), .none_n(nn8));

    // Reference: scan from the top line downward.
    function automatic void ref_model(input int pat, input int lines,
                                      output int ridx, output bit rnn);
        ridx = 0;
        rnn  = 1'b1;
        for (int b = lines - 1; b >= 0; b--) begin
            if (rnn && ((pat >> b) & 1) == 1) begin
                ridx = b;
                rnn  = 1'b0;
            end
        end
    endfunction

    // Driver: apply one pattern after a rising edge and queue its prediction.
    task automatic drive(input bit wide, input int pat, input string tag);
        exp_t e;
        @(posedge clk);
        if (wide) req8 <= 8'(pat); else req4 <= 4'(pat);
        e.wide = wide;
        e.pat  = pat;
        e.tag  = tag;
        ref_model(pat, wide ? 8 : 4, e.idx, e.nn);
        sb.push_back(e);
    endtask

    // Monitor: at each falling edge compare the oldest prediction.
    always @(negedge clk) begin
        if (rst_n && sb.size() > 0) begin
            exp_t e;
            int   aidx;
            bit   ann;
            e = sb.pop_front();
            aidx = e.wide ? int'(idx8) : int'(idx4);
            ann  = e.wide ? nn8 : nn4;
            checks++;
            if (aidx != e.idx || ann != e.nn) begin
                errors++;
                $display("FAIL %s pat=%0h actual idx=%0d none_n=%0b expected idx=%0d none_n=%0b",
                         e.tag, e.pat, aidx, ann, e.idx, e.nn);
            end
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        // Reset-state check: idle inputs before any stimulus (R1, R2).
        @(negedge clk);
        checks++;
        if (nn4 !== 1'b1 || idx4 !== 2'd0) begin
            errors++;
            $display("FAIL R1/R2 reset state actual idx=%0d none_n=%0b expected idx=0 none_n=1", idx4, nn4);
        end
        rst_n = 1'b1;
        // Idle vs line 0, back to back (R1 R2 R5).
        drive(0, 0, "R1_R2 idle");
        drive(0, 1, "R5 line0");
        drive(0, 0, "R2 idle again");
        // Single-hot lines (R5).
        for (int p = 0; p < 4; p++) drive(0, 1 << p, "R5 onehot");
        // Lower lines masked (R6).
        drive(0, 4'hF, "R6 all ones");
        drive(0, 4'h8, "R6 top only");
        drive(0, 4'h7, "R6 lower three");
        // Exhaustive four-line sweep (R3 R4 R7).
        for (int p = 0; p < 16; p++) drive(0, p, "R3_R4_R7 sweep4");
        // Eight-line instance, all patterns (R8).
        for (int p = 0; p < 256; p++) drive(1, p, "R8 sweep8");
        @(posedge clk);
        @(posedge clk);
        done = 1;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual hung expected finish");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule